// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register bank behind a processor's system-control coprocessor. The pipeline issues one move-to or move-from transfer per cycle. Each transfer carries two opcode fields, a primary and a secondary register number, the index of the core register involved, a direction bit, and 32-bit write data. One cycle after the request, the block returns read data and a flag that marks the access as undefined. The pipeline uses that flag to take an undefined-instruction trap.

The bank holds the following:
- fixed identification and cache-type words, set by parameters;
- the main and auxiliary control words;
- the translation base, 16 KB aligned;
- the domain access word;
- an 8-bit fault status;
- the fault address;
- a process identifier that must stay zero;
- a coprocessor access word.

A write to the TLB register number stores nothing. Instead it produces a one-cycle invalidate strobe, either for the whole TLB or for a single virtual address. Five control bits drive enable levels for the MMU, alignment checking, the data cache, the write buffer and the instruction cache. Cache maintenance, lockdown and debug register numbers accept writes and ignore them.

Top module: `sysctl_cp_regs`

## Requirements
- R1: After reset, every writable register reads zero, all enable outputs, strobes and the alignment warning are low, and no response is valid.
- R2: A request whose primary opcode is nonzero, or whose transfer register index is 15, is undefined. It changes no state and raises no strobe.
- R3: With register number 0, secondary opcode 0 reads the ID parameter and secondary opcode 1 reads the cache-type parameter. Writes to either are accepted but have no effect. Any other secondary opcode is undefined.
- R4: With register number 1, secondary opcode 0 selects the control word and 1 selects the auxiliary word. Other secondary opcodes are undefined. After a control write, these control bits drive the enable outputs: bit 0 the MMU, bit 1 alignment, bit 2 the data cache, bit 3 the write buffer, bit 12 the instruction cache.
- R5: A control write that would change bit 7 (byte order) is undefined and leaves the control word unchanged.
- R6: The translation base (register number 2) stores and returns the write data with bits 13:0 cleared. A write with any of bits 13:0 set raises a sticky warning output that stays set until reset.
- R7: The fault status (register number 5) keeps only bits 7:0. Bits 31:8 read as zero.
- R8: The domain access word (register number 3) and the fault address (register number 6) are full 32-bit read/write registers. So is the access word at register number 15 with secondary register 1. Register number 15 with any other secondary register is undefined.
- R9: A write to register number 8 with secondary opcode 0 pulses the invalidate-all strobe for one cycle. With any other secondary opcode it pulses the invalidate-by-address strobe, and the address output carries the write data. Reads of register numbers 7 and 8 are undefined.
- R10: The process ID (register number 13) needs secondary opcode 0 and secondary register 0; any other values are undefined. A nonzero write is undefined. A read returns zero.
- R11: Writes to register numbers 7, 9 and 14 are accepted and have no effect. Reads of 9 and 14 return zero. Register numbers 4, 10, 11 and 12 are undefined.
- R12: A response is valid exactly one cycle after an accepted request, with the undefined flag in that same cycle. Read data is zero for writes and for undefined accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request present |
| req_read_i | input | 1 | 1 = move from coprocessor (read), 0 = write |
| req_op1_i | input | 3 | Primary opcode |
| req_op2_i | input | 3 | Secondary opcode |
| req_crn_i | input | 4 | Primary register number |
| req_crm_i | input | 4 | Secondary register number |
| req_rt_i | input | 4 | Core register index of the transfer |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 32 | Read data |
| rsp_undef_o | output | 1 | Access undefined |
| tlb_inv_all_o | output | 1 | Invalidate whole TLB, one cycle |
| tlb_inv_va_o | output | 1 | Invalidate one address, one cycle |
| tlb_va_o | output | 32 | Address for invalidate-by-address |
| mmu_en_o | output | 1 | MMU enable |
| align_en_o | output | 1 | Alignment check enable |
| dcache_en_o | output | 1 | Data cache enable |
| wbuf_en_o | output | 1 | Write buffer enable |
| icache_en_o | output | 1 | Instruction cache enable |
| base_warn_o | output | 1 | Sticky warning: misaligned translation base written |

## Verification
Two things can happen in the same cycle. One is the response to one request; the other is a state change made by the request issued right before it. The bench provokes this by sending a control write and a control read back to back with no gap. It then requires two results: the read returns the new word, and the enable outputs have already changed when that read's response appears. A TLB write can also share its response cycle with the next request's decode. The bench checks that the strobe is high only in that response cycle, and low one cycle later once the bus goes idle.

// File: rtl/sccp_pkg.sv
package sccp_pkg;
  localparam int DATA_W  = 32;
  localparam int OPC_W   = 3;
  localparam int IDX_W   = 4;
  localparam int FSR_W   = 8;
  localparam int TTB_LSB = 14;

  localparam int CTRL_MMU   = 0;
  localparam int CTRL_ALIGN = 1;
  localparam int CTRL_DC    = 2;
  localparam int CTRL_WB    = 3;
  localparam int CTRL_BIG   = 7;
  localparam int CTRL_IC    = 12;

  localparam logic [IDX_W-1:0] RT_PC = '1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_AUX, SEL_TTB,
    SEL_DACR, SEL_FSR, SEL_FAR, SEL_PID, SEL_CPAR, SEL_TLB, SEL_NOP
  } reg_sel_e;
endpackage

// File: rtl/sccp_decode.sv
module sccp_decode
  import sccp_pkg::*;
(
  input  logic              read_i,
  input  logic [OPC_W-1:0]  op1_i,
  input  logic [OPC_W-1:0]  op2_i,
  input  logic [IDX_W-1:0]  crn_i,
  input  logic [IDX_W-1:0]  crm_i,
  input  logic [IDX_W-1:0]  rt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ctrl_big_i,
  output reg_sel_e          sel_o,
  output logic              undef_o
);
  always_comb begin
    sel_o   = SEL_NONE;
    undef_o = 1'b0;
    if (op1_i != '0 || rt_i == RT_PC) begin
      undef_o = 1'b1;
    end else begin
      case (crn_i)
        4'd0: begin
          if (op2_i == 3'd0)      sel_o = SEL_ID;
          else if (op2_i == 3'd1) sel_o = SEL_CTYPE;
          else                    undef_o = 1'b1;
        end
        4'd1: begin
          if (op2_i == 3'd0) begin
            sel_o = SEL_CTRL;
            if (!read_i && (wdata_i[CTRL_BIG] != ctrl_big_i)) undef_o = 1'b1;
          end else if (op2_i == 3'd1) begin
            sel_o = SEL_AUX;
          end else begin
            undef_o = 1'b1;
          end
        end
        4'd2:  sel_o = SEL_TTB;
        4'd3:  sel_o = SEL_DACR;
        4'd5:  sel_o = SEL_FSR;
        4'd6:  sel_o = SEL_FAR;
        4'd7: begin
          if (read_i) undef_o = 1'b1;
          else        sel_o = SEL_NOP;
        end
        4'd8: begin
          if (read_i) undef_o = 1'b1;
          else        sel_o = SEL_TLB;
        end
        4'd9, 4'd14: sel_o = SEL_NOP;
        4'd13: begin
          if (op2_i != '0 || crm_i != '0)      undef_o = 1'b1;
          else if (!read_i && wdata_i != '0)   undef_o = 1'b1;
          else                                 sel_o = SEL_PID;
        end
        4'd15: begin
          if (crm_i == 4'd1) sel_o = SEL_CPAR;
          else               undef_o = 1'b1;
        end
        default: undef_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sccp_regs.sv
module sccp_regs
  import sccp_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE    = 32'h6900_B201,
  parameter logic [DATA_W-1:0] CTYPE_VALUE = 32'h0B1A_A1AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              warn_o
);
  localparam int N_PLAIN = 3;
  localparam reg_sel_e PLAIN_SEL [N_PLAIN] = '{SEL_DACR, SEL_FAR, SEL_CPAR};

  logic [DATA_W-1:0]       ctrl_q, aux_q;
  logic [DATA_W-1:TTB_LSB] ttb_hi_q;
  logic [FSR_W-1:0]        fsr_q;
  logic                    warn_q;
  logic [DATA_W-1:0]       plain_q [N_PLAIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      aux_q    <= '0;
      ttb_hi_q <= '0;
      fsr_q    <= '0;
      warn_q   <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        SEL_CTRL: ctrl_q <= wdata_i;
        SEL_AUX:  aux_q  <= wdata_i;
        SEL_FSR:  fsr_q  <= wdata_i[FSR_W-1:0];
        SEL_TTB: begin
          ttb_hi_q <= wdata_i[DATA_W-1:TTB_LSB];
          if (|wdata_i[TTB_LSB-1:0]) warn_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              plain_q[g] <= '0;
      else if (we_i && sel_i == PLAIN_SEL[g])   plain_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_ID:    rdata_o = ID_VALUE;
      SEL_CTYPE: rdata_o = CTYPE_VALUE;
      SEL_CTRL:  rdata_o = ctrl_q;
      SEL_AUX:   rdata_o = aux_q;
      SEL_TTB:   rdata_o = {ttb_hi_q, {TTB_LSB{1'b0}}};
      SEL_FSR:   rdata_o = {{(DATA_W-FSR_W){1'b0}}, fsr_q};
      default: begin
        for (int k = 0; k < N_PLAIN; k++)
          if (sel_i == PLAIN_SEL[k]) rdata_o = plain_q[k];
      end
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign warn_o = warn_q;

  AST_BIG_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_BIG] == 1'b0); // R5
  AST_WARN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(warn_q)); // R6
endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
  import sccp_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h6900_B201,
  parameter logic [31:0] CTYPE_VALUE = 32'h0B1A_A1AA
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_read_i,
  input  logic [2:0]  req_op1_i,
  input  logic [2:0]  req_op2_i,
  input  logic [3:0]  req_crn_i,
  input  logic [3:0]  req_crm_i,
  input  logic [3:0]  req_rt_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_undef_o,
  output logic        tlb_inv_all_o,
  output logic        tlb_inv_va_o,
  output logic [31:0] tlb_va_o,
  output logic        mmu_en_o,
  output logic        align_en_o,
  output logic        dcache_en_o,
  output logic        wbuf_en_o,
  output logic        icache_en_o,
  output logic        base_warn_o
);
  reg_sel_e          sel;
  logic              undef;
  logic [DATA_W-1:0] rdata, ctrl_q;
  logic              accept, wr_en, tlb_wr;

  sccp_decode u_decode (
    .read_i     (req_read_i),
    .op1_i      (req_op1_i),
    .op2_i      (req_op2_i),
    .crn_i      (req_crn_i),
    .crm_i      (req_crm_i),
    .rt_i       (req_rt_i),
    .wdata_i    (req_wdata_i),
    .ctrl_big_i (ctrl_q[CTRL_BIG]),
    .sel_o      (sel),
    .undef_o    (undef)
  );

  assign accept = req_valid_i && !undef;
  assign wr_en  = accept && !req_read_i;
  assign tlb_wr = wr_en && sel == SEL_TLB;

  sccp_regs #(
    .ID_VALUE    (ID_VALUE),
    .CTYPE_VALUE (CTYPE_VALUE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .sel_i   (sel),
    .wdata_i (req_wdata_i),
    .rdata_o (rdata),
    .ctrl_o  (ctrl_q),
    .warn_o  (base_warn_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_undef_o   <= 1'b0;
      rsp_rdata_o   <= '0;
      tlb_inv_all_o <= 1'b0;
      tlb_inv_va_o  <= 1'b0;
      tlb_va_o      <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_undef_o   <= req_valid_i && undef;
      rsp_rdata_o   <= (accept && req_read_i) ? rdata : '0;
      tlb_inv_all_o <= tlb_wr && req_op2_i == '0;
      tlb_inv_va_o  <= tlb_wr && req_op2_i != '0;
      if (tlb_wr && req_op2_i != '0) tlb_va_o <= req_wdata_i;
    end
  end

  assign mmu_en_o    = ctrl_q[CTRL_MMU];
  assign align_en_o  = ctrl_q[CTRL_ALIGN];
  assign dcache_en_o = ctrl_q[CTRL_DC];
  assign wbuf_en_o   = ctrl_q[CTRL_WB];
  assign icache_en_o = ctrl_q[CTRL_IC];

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i)); // R12
  AST_UNDEF_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_undef_o |-> rsp_valid_o && rsp_rdata_o == '0); // R12
  AST_UNDEF_NO_CTRL_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_undef_o |-> $stable(ctrl_q)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tlb_inv_all_o, tlb_inv_va_o}) <= 1); // R9
  AST_STROBE_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_inv_all_o || tlb_inv_va_o) |-> rsp_valid_o && !rsp_undef_o); // R9
endmodule

// File: tb/sysctl_cp_regs_bench.sv
module sysctl_cp_regs_bench;
  localparam logic [31:0] IDV = 32'h6900_B201;
  localparam logic [31:0] CTV = 32'h0B1A_A1AA;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [3:0]  req_crn = '0, req_crm = '0, req_rt = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_undef, inv_all, inv_va;
  logic [31:0] rsp_rdata, tlb_va;
  logic        mmu_en, align_en, dc_en, wb_en, ic_en, warn;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_d [$];
  bit          exp_u [$];
  string       exp_t [$];

  always #5 clk = ~clk;

  sysctl_cp_regs #(.ID_VALUE(IDV), .CTYPE_VALUE(CTV)) u_sysctl_cp_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_read_i(req_read),
    .req_op1_i(req_op1), .req_op2_i(req_op2), .req_crn_i(req_crn), .req_crm_i(req_crm),
    .req_rt_i(req_rt), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_undef_o(rsp_undef), .tlb_inv_all_o(inv_all),
    .tlb_inv_va_o(inv_va), .tlb_va_o(tlb_va), .mmu_en_o(mmu_en), .align_en_o(align_en),
    .dcache_en_o(dc_en), .wbuf_en_o(wb_en), .icache_en_o(ic_en), .base_warn_o(warn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit rd, input logic [2:0] o1, input logic [2:0] o2,
                       input logic [3:0] n, input logic [3:0] m, input logic [3:0] t,
                       input logic [31:0] wd, input logic [31:0] er, input bit eu,
                       input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_op1 = o1; req_op2 = o2;
    req_crn = n; req_crm = m; req_rt = t; req_wdata = wd;
    exp_d.push_back(er); exp_u.push_back(eu); exp_t.push_back(tag);
  endtask

  task automatic rdr(input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2,
                     input logic [31:0] er, input bit eu, input string tag);
    issue(1'b1, 3'd0, o2, n, m, 4'd1, 32'h0, eu ? 32'h0 : er, eu, tag);
  endtask

  task automatic wrr(input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2,
                     input logic [31:0] wd, input bit eu, input string tag);
    issue(1'b0, 3'd0, o2, n, m, 4'd2, wd, 32'h0, eu, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R12 unexpected response", {31'b0, rsp_valid}, 32'h0);
      end else begin
        logic [31:0] ed; bit eu; string et;
        ed = exp_d.pop_front(); eu = exp_u.pop_front(); et = exp_t.pop_front();
        chk(rsp_rdata === ed, {et, " rdata"}, rsp_rdata, ed);
        chk(rsp_undef === eu, {et, " undef"}, {31'b0, rsp_undef}, {31'b0, eu});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk({mmu_en, align_en, dc_en, wb_en, ic_en, inv_all, inv_va, warn} === 8'h0,
        "R1 outputs", {24'b0, mmu_en, align_en, dc_en, wb_en, ic_en, inv_all, inv_va, warn}, 32'h0);
    rdr(4'd1, 4'd0, 3'd0, 32'h0, 1'b0, "R1 control reset");
    rdr(4'd2, 4'd0, 3'd0, 32'h0, 1'b0, "R1 base reset");
    rdr(4'd6, 4'd0, 3'd0, 32'h0, 1'b0, "R1 far reset");

    // R3 identification
    rdr(4'd0, 4'd0, 3'd0, IDV, 1'b0, "R3 id");
    rdr(4'd0, 4'd0, 3'd1, CTV, 1'b0, "R3 ctype");
    wrr(4'd0, 4'd0, 3'd0, 32'hFFFF_FFFF, 1'b0, "R3 id write");
    rdr(4'd0, 4'd0, 3'd0, IDV, 1'b0, "R3 id after write");
    rdr(4'd0, 4'd0, 3'd2, 32'h0, 1'b1, "R3 bad op2");

    // R4 control, back-to-back write then read
    wrr(4'd1, 4'd0, 3'd0, 32'h0000_100F, 1'b0, "R4 control write");
    rdr(4'd1, 4'd0, 3'd0, 32'h0000_100F, 1'b0, "R4 control readback");
    chk({mmu_en, align_en, dc_en, wb_en, ic_en} === 5'h1F, "R4 enables",
        {27'b0, mmu_en, align_en, dc_en, wb_en, ic_en}, 32'h1F);
    wrr(4'd1, 4'd0, 3'd1, 32'h0000_0033, 1'b0, "R4 aux write");
    rdr(4'd1, 4'd0, 3'd1, 32'h0000_0033, 1'b0, "R4 aux read");
    rdr(4'd1, 4'd0, 3'd2, 32'h0, 1'b1, "R4 bad op2 read");
    wrr(4'd1, 4'd0, 3'd3, 32'h1, 1'b1, "R4 bad op2 write");

    // R5 byte order change rejected
    wrr(4'd1, 4'd0, 3'd0, 32'h0000_0080, 1'b1, "R5 endian write");
    rdr(4'd1, 4'd0, 3'd0, 32'h0000_100F, 1'b0, "R5 control kept");

    // R2 illegal forms
    issue(1'b1, 3'd1, 3'd0, 4'd1, 4'd0, 4'd1, 32'h0, 32'h0, 1'b1, "R2 op1 read");
    issue(1'b0, 3'd2, 3'd0, 4'd1, 4'd0, 4'd1, 32'h0, 32'h0, 1'b1, "R2 op1 write");
    issue(1'b0, 3'd0, 3'd1, 4'd1, 4'd0, 4'd15, 32'h0, 32'h0, 1'b1, "R2 pc write");
    issue(1'b0, 3'd0, 3'd0, 4'd8, 4'd0, 4'd15, 32'h0, 32'h0, 1'b1, "R2 pc tlb");
    rdr(4'd1, 4'd0, 3'd0, 32'h0000_100F, 1'b0, "R2 control kept");
    chk(inv_all === 1'b0, "R2 no strobe", {31'b0, inv_all}, 32'h0);
    rdr(4'd1, 4'd0, 3'd1, 32'h0000_0033, 1'b0, "R2 aux kept");

    // R6 translation base
    wrr(4'd2, 4'd0, 3'd0, 32'h1234_4000, 1'b0, "R6 aligned write");
    rdr(4'd2, 4'd0, 3'd0, 32'h1234_4000, 1'b0, "R6 aligned read");
    chk(warn === 1'b0, "R6 no warn", {31'b0, warn}, 32'h0);
    wrr(4'd2, 4'd0, 3'd0, 32'hABCD_E123, 1'b0, "R6 misaligned write");
    rdr(4'd2, 4'd0, 3'd0, 32'hABCD_C000, 1'b0, "R6 masked read");
    chk(warn === 1'b1, "R6 warn set", {31'b0, warn}, 32'h1);
    wrr(4'd2, 4'd0, 3'd0, 32'h0000_8000, 1'b0, "R6 second write");
    idle();
    chk(warn === 1'b1, "R6 warn sticky", {31'b0, warn}, 32'h1);

    // R7 fault status, R8 full registers
    wrr(4'd5, 4'd0, 3'd0, 32'hFFFF_FFA5, 1'b0, "R7 fsr write");
    rdr(4'd5, 4'd0, 3'd0, 32'h0000_00A5, 1'b0, "R7 fsr read");
    wrr(4'd3, 4'd0, 3'd0, 32'h5555_AAAA, 1'b0, "R8 dacr write");
    wrr(4'd6, 4'd0, 3'd0, 32'hDEAD_BEEF, 1'b0, "R8 far write");
    wrr(4'd15, 4'd1, 3'd0, 32'h0000_3FFF, 1'b0, "R8 cpar write");
    rdr(4'd3, 4'd0, 3'd0, 32'h5555_AAAA, 1'b0, "R8 dacr read");
    rdr(4'd6, 4'd0, 3'd0, 32'hDEAD_BEEF, 1'b0, "R8 far read");
    rdr(4'd15, 4'd1, 3'd0, 32'h0000_3FFF, 1'b0, "R8 cpar read");
    rdr(4'd15, 4'd0, 3'd0, 32'h0, 1'b1, "R8 crn15 bad crm");

    // R9 TLB strobes
    wrr(4'd8, 4'd7, 3'd0, 32'h0, 1'b0, "R9 inv all");
    idle();
    chk(inv_all === 1'b1 && inv_va === 1'b0, "R9 inv all strobe",
        {30'b0, inv_all, inv_va}, 32'h2);
    idle();
    chk(inv_all === 1'b0, "R9 inv all single cycle", {31'b0, inv_all}, 32'h0);
    wrr(4'd8, 4'd5, 3'd1, 32'hC000_1000, 1'b0, "R9 inv va");
    idle();
    chk(inv_va === 1'b1 && inv_all === 1'b0, "R9 inv va strobe",
        {30'b0, inv_all, inv_va}, 32'h1);
    chk(tlb_va === 32'hC000_1000, "R9 va", tlb_va, 32'hC000_1000);
    idle();
    chk(inv_va === 1'b0, "R9 inv va single cycle", {31'b0, inv_va}, 32'h0);
    rdr(4'd8, 4'd0, 3'd0, 32'h0, 1'b1, "R9 read crn8");
    rdr(4'd7, 4'd0, 3'd0, 32'h0, 1'b1, "R9 read crn7");

    // R10 process id
    rdr(4'd13, 4'd0, 3'd0, 32'h0, 1'b0, "R10 pid read");
    wrr(4'd13, 4'd0, 3'd0, 32'h0, 1'b0, "R10 pid zero write");
    wrr(4'd13, 4'd0, 3'd0, 32'h0000_0005, 1'b1, "R10 pid nonzero");
    rdr(4'd13, 4'd0, 3'd0, 32'h0, 1'b0, "R10 pid still zero");
    rdr(4'd13, 4'd0, 3'd1, 32'h0, 1'b1, "R10 pid op2");
    rdr(4'd13, 4'd1, 3'd0, 32'h0, 1'b1, "R10 pid crm");

    // R11 no-effect and undefined numbers
    wrr(4'd7, 4'd5, 3'd0, 32'hFFFF_FFFF, 1'b0, "R11 cache op");
    wrr(4'd9, 4'd0, 3'd0, 32'hFFFF_FFFF, 1'b0, "R11 lockdown write");
    wrr(4'd14, 4'd0, 3'd0, 32'hFFFF_FFFF, 1'b0, "R11 debug write");
    rdr(4'd9, 4'd0, 3'd0, 32'h0, 1'b0, "R11 lockdown read");
    rdr(4'd14, 4'd0, 3'd0, 32'h0, 1'b0, "R11 debug read");
    rdr(4'd4, 4'd0, 3'd0, 32'h0, 1'b1, "R11 crn4");
    wrr(4'd11, 4'd0, 3'd0, 32'h1, 1'b1, "R11 crn11");
    rdr(4'd1, 4'd0, 3'd0, 32'h0000_100F, 1'b0, "R11 control untouched");

    // R12 idle gap yields no response
    idle();
    idle();
    chk(rsp_valid === 1'b0, "R12 idle no response", {31'b0, rsp_valid}, 32'h0);
    chk(exp_d.size() == 0, "R12 all responses seen", exp_d.size(), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule